// File: doc/BRIEF.md
# Scaler Mode and Black-Level Offset Selector

This block picks the operating mode of a display scaler from the source pixel format and from four flags. Each flag says whether one of the four scale ratios is exactly one: luma horizontal, luma vertical, chroma horizontal or chroma vertical. It also produces the black-level offsets the scaler adds to the luma/RGB and chroma channels. A configuration sequencer uses two skip outputs to leave out programming steps that the chosen mode does not need.

The mode comes from a fixed-priority chain. The first rule is a full scaler bypass for half-float sources on parts that process in fixed format. Next comes a plain 4:4:4 bypass when no ratio scales and scaling is not forced. Non-4:2:0 sources then scale as RGB or YCbCr. A 4:2:0 source resolves to a luma-only bypass, a chroma-only bypass or full 4:2:0 scaling. All results are captured on a load strobe and held until the next one.

Top module: `scl_mode_resolver`

## Requirements
- R1: Format codes are 0 = RGB, 1 = YCbCr 4:4:4 video, 2 = 4:2:0 8-bit, 3 = 4:2:0 10-bit, 4 = FP16. Modes are 0 = 4:4:4 bypass, 1 = 4:4:4 RGB scaling, 2 = 4:4:4 YCbCr scaling, 3 = 4:2:0 scaling, 4 = 4:2:0 luma bypass, 5 = 4:2:0 chroma bypass, 6 = full bypass. When fixed_fmt_cap is 1 and the format is 4, the mode is 6, whatever the other inputs are.
- R2: If R1 does not apply, all four unity flags are 1 and force_scale is 0, the mode is 0.
- R3: If neither R1 nor R2 applies and the format is not 2 or 3, the mode is 2 for format 1 and 1 for every other code. FP16 without the fixed-format capability, and the unknown codes 5 to 7, count as RGB.
- R4: If neither R1 nor R2 applies and the format is 2 or 3, the mode is 4 when both luma flags are 1. Otherwise it is 5 when both chroma flags are 1. Otherwise it is 3.
- R5: black_luma is always 0x0000. black_chroma is 0x8000 for formats 1, 2 and 3 and 0x0000 for all other codes, whatever the mode.
- R6: skip_lb is 1 exactly when the mode is 6. skip_filter is 1 exactly when the mode is 0 or 6.
- R7: The outputs take new values in the cycle after a clock edge on which load is 1. Without load they keep their values, whatever the other inputs do.
- R8: After reset the outputs are mode 0, both offsets 0, skip_lb 0 and skip_filter 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| load | input | 1 | Captures a new result from the present inputs |
| fmt | input | 3 | Source pixel format code |
| fixed_fmt_cap | input | 1 | Scaler processes data in fixed format |
| force_scale | input | 1 | Debug: never pick the 4:4:4 bypass |
| luma_h_unity | input | 1 | Luma horizontal ratio is exactly one |
| luma_v_unity | input | 1 | Luma vertical ratio is exactly one |
| chroma_h_unity | input | 1 | Chroma horizontal ratio is exactly one |
| chroma_v_unity | input | 1 | Chroma vertical ratio is exactly one |
| mode | output | 3 | Selected scaler mode |
| black_luma | output | 16 | Black offset for luma/RGB |
| black_chroma | output | 16 | Black offset for chroma |
| skip_lb | output | 1 | Sequencer skips line-buffer setup |
| skip_filter | output | 1 | Sequencer skips filter setup |

## Verification
Every output is due exactly one clock after the edge that samples load high. The bench drives inputs on the falling edge, lets one rising edge pass, and compares on the next falling edge. It sweeps all 512 combinations of format code and flags. After each load it scrambles the inputs with load low for one cycle and checks again, so the hold behaviour is seen at the ports in the cycle where a wrongly loaded value would show.

// File: rtl/scl_mode_pkg.sv
package scl_mode_pkg;
  localparam int FMT_W  = 3;
  localparam int MODE_W = 3;

  typedef enum logic [MODE_W-1:0] {
    MODE_444_BYPASS = 3'd0,
    MODE_444_RGB    = 3'd1,
    MODE_444_YCC    = 3'd2,
    MODE_420_SCALE  = 3'd3,
    MODE_420_LUMA_BP = 3'd4,
    MODE_420_CHR_BP = 3'd5,
    MODE_FULL_BP    = 3'd6
  } scl_mode_e;

  localparam logic [FMT_W-1:0] FMT_RGB    = 3'd0;
  localparam logic [FMT_W-1:0] FMT_YCC444 = 3'd1;
  localparam logic [FMT_W-1:0] FMT_420_8  = 3'd2;
  localparam logic [FMT_W-1:0] FMT_420_10 = 3'd3;
  localparam logic [FMT_W-1:0] FMT_FP16   = 3'd4;

  typedef struct packed {
    logic fp16;
    logic sub420;
    logic video;
  } fmt_class_t;
endpackage

// File: rtl/scl_fmt_decode.sv
module scl_fmt_decode
  import scl_mode_pkg::*;
(
  input  logic [FMT_W-1:0] fmt,
  output fmt_class_t       cls
);
  always_comb begin
    cls = '0;
    unique case (fmt)
      FMT_YCC444:           cls.video  = 1'b1;
      FMT_420_8, FMT_420_10: begin
        cls.video  = 1'b1;
        cls.sub420 = 1'b1;
      end
      FMT_FP16:             cls.fp16   = 1'b1;
      default:              cls        = '0; // RGB and unknown codes
    endcase
  end
endmodule

// File: rtl/scl_mode_chain.sv
module scl_mode_chain
  import scl_mode_pkg::*;
(
  input  fmt_class_t cls,
  input  logic       fixed_fmt_cap,
  input  logic       force_scale,
  input  logic       luma_h_unity,
  input  logic       luma_v_unity,
  input  logic       chroma_h_unity,
  input  logic       chroma_v_unity,
  output scl_mode_e  mode
);
  logic luma_one, chroma_one;
  assign luma_one   = luma_h_unity & luma_v_unity;
  assign chroma_one = chroma_h_unity & chroma_v_unity;

  always_comb begin
    if (fixed_fmt_cap && cls.fp16)
      mode = MODE_FULL_BP;
    else if (luma_one && chroma_one && !force_scale)
      mode = MODE_444_BYPASS;
    else if (!cls.sub420)
      mode = cls.video ? MODE_444_YCC : MODE_444_RGB;
    else if (luma_one)
      mode = MODE_420_LUMA_BP;
    else if (chroma_one)
      mode = MODE_420_CHR_BP;
    else
      mode = MODE_420_SCALE;
  end
endmodule

// File: rtl/scl_mode_resolver.sv
module scl_mode_resolver
  import scl_mode_pkg::*;
#(
  parameter int OFS_W = 16
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               load,
  input  logic [FMT_W-1:0]   fmt,
  input  logic               fixed_fmt_cap,
  input  logic               force_scale,
  input  logic               luma_h_unity,
  input  logic               luma_v_unity,
  input  logic               chroma_h_unity,
  input  logic               chroma_v_unity,
  output logic [MODE_W-1:0]  mode,
  output logic [OFS_W-1:0]   black_luma,
  output logic [OFS_W-1:0]   black_chroma,
  output logic               skip_lb,
  output logic               skip_filter
);
  localparam logic [OFS_W-1:0] CHROMA_MID = OFS_W'(1) << (OFS_W - 1);
  localparam logic [OFS_W-1:0] ZERO_OFS   = '0;

  fmt_class_t cls;
  scl_mode_e  mode_d;

  scl_fmt_decode u_dec (.fmt(fmt), .cls(cls));

  scl_mode_chain u_chain (
    .cls(cls), .fixed_fmt_cap(fixed_fmt_cap), .force_scale(force_scale),
    .luma_h_unity(luma_h_unity), .luma_v_unity(luma_v_unity),
    .chroma_h_unity(chroma_h_unity), .chroma_v_unity(chroma_v_unity),
    .mode(mode_d)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      mode         <= MODE_444_BYPASS;
      black_luma   <= ZERO_OFS;
      black_chroma <= ZERO_OFS;
      skip_lb      <= 1'b0;
      skip_filter  <= 1'b1;
    end else if (load) begin
      mode         <= mode_d;
      black_luma   <= ZERO_OFS;
      black_chroma <= cls.video ? CHROMA_MID : ZERO_OFS;
      skip_lb      <= (mode_d == MODE_FULL_BP);
      skip_filter  <= (mode_d == MODE_FULL_BP) || (mode_d == MODE_444_BYPASS);
    end
  end

  // R1
  full_bp_chk: assert property (@(posedge clk) disable iff (rst)
    (load && fixed_fmt_cap && fmt == FMT_FP16) |=> (mode == MODE_FULL_BP));

  // R1
  mode_range_chk: assert property (@(posedge clk) disable iff (rst)
    mode != 3'd7);

  // R5
  luma_ofs_chk: assert property (@(posedge clk) disable iff (rst)
    black_luma == ZERO_OFS);

  // R5
  rgb_chroma_chk: assert property (@(posedge clk) disable iff (rst)
    (mode == MODE_444_RGB) |-> (black_chroma == ZERO_OFS));

  // R6
  skip_lb_chk: assert property (@(posedge clk) disable iff (rst)
    skip_lb == (mode == MODE_FULL_BP));

  // R6
  skip_filter_chk: assert property (@(posedge clk) disable iff (rst)
    skip_lb |-> skip_filter);

  // R7
  hold_chk: assert property (@(posedge clk) disable iff (rst)
    !load |=> ($stable(mode) && $stable(black_chroma) && $stable(skip_filter)));
endmodule

// File: tb/scl_mode_resolver_bench.sv
module scl_mode_resolver_bench;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic load = 1'b0;
  logic [2:0] fmt = 3'd0;
  logic cap = 1'b0, force_s = 1'b0, lh = 1'b0, lv = 1'b0, ch = 1'b0, cv = 1'b0;
  logic [2:0]  mode;
  logic [15:0] bl, bc;
  logic        slb, sflt;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #2 clk = ~clk; // 250 MHz

  scl_mode_resolver u_scl_mode_resolver (
    .clk(clk), .rst(rst), .load(load), .fmt(fmt), .fixed_fmt_cap(cap),
    .force_scale(force_s), .luma_h_unity(lh), .luma_v_unity(lv),
    .chroma_h_unity(ch), .chroma_v_unity(cv), .mode(mode),
    .black_luma(bl), .black_chroma(bc), .skip_lb(slb), .skip_filter(sflt)
  );

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic int exp_mode(input int f, input bit c, input bit fs,
                                  input bit a, input bit b, input bit d, input bit e);
    if (c && f == 4) return 6;
    if (a && b && d && e && !fs) return 0;
    if (f != 2 && f != 3) return (f == 1) ? 2 : 1;
    if (a && b) return 4;
    if (d && e) return 5;
    return 3;
  endfunction

  function automatic string mode_tag(input int f, input bit c, input bit fs,
                                     input bit a, input bit b, input bit d, input bit e);
    if (c && f == 4) return "R1";
    if (a && b && d && e && !fs) return "R2";
    if (f != 2 && f != 3) return "R3";
    return "R4";
  endfunction

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R8 mode", int'(mode), 0);
    chk("R8 black_luma", int'(bl), 0);
    chk("R8 black_chroma", int'(bc), 0);
    chk("R8 skip_lb", int'(slb), 0);
    chk("R8 skip_filter", int'(sflt), 1);

    for (int v = 0; v < 512; v++) begin
      int em, ec;
      logic [8:0] bits;
      bits = 9'(v);
      fmt = bits[8:6]; cap = bits[5]; force_s = bits[4];
      lh = bits[3]; lv = bits[2]; ch = bits[1]; cv = bits[0];
      em = exp_mode(int'(fmt), cap, force_s, lh, lv, ch, cv);
      ec = (fmt == 1 || fmt == 2 || fmt == 3) ? 32'h8000 : 0;
      load = 1'b1;
      @(negedge clk);
      load = 1'b0;
      chk(mode_tag(int'(fmt), cap, force_s, lh, lv, ch, cv), int'(mode), em);
      chk("R5 black_luma", int'(bl), 0);
      chk("R5 black_chroma", int'(bc), ec);
      chk("R6 skip_lb", int'(slb), (em == 6) ? 1 : 0);
      chk("R6 skip_filter", int'(sflt), (em == 6 || em == 0) ? 1 : 0);
      // scramble inputs without load; outputs must hold
      fmt = ~fmt; cap = ~cap; force_s = ~force_s;
      lh = ~lh; lv = ~lv; ch = ~ch; cv = ~cv;
      @(negedge clk);
      chk("R7 hold mode", int'(mode), em);
      chk("R7 hold black_chroma", int'(bc), ec);
    end

    // reset in the middle of operation returns to the reset state
    fmt = 3'd4; cap = 1'b1; load = 1'b1;
    @(negedge clk);
    load = 1'b0;
    chk("R1 full bypass before reset", int'(mode), 6);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    chk("R8 mode after reset", int'(mode), 0);
    chk("R8 skip_filter after reset", int'(sflt), 1);

    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (10000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++;
      errors++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule